// File: doc/BRIEF.md
# Flash Access Security Gate

This block decides whether an external programming tool may touch an on-chip flash array. Straight after reset it walks a fixed list of flash locations through a simple read port. It reads the four reset-vector bytes, then a protection byte, and then, unless the vector is blank, seven identification bytes that sit at scattered addresses. The flash array, the erase and program engines, and the serial framing are outside this block.

In serial programming mode the tool streams an identification code, one byte at a time, and closes it with an end strobe. The gate compares the whole submission with the stored code and latches a pass or fail verdict, which enables or rejects the tool's later commands. A blank reset vector (all ones) means the comparison is skipped and every command is accepted. In parallel programming mode the identification code plays no part. A two-bit field in the protection byte then decides whether reads and rewrites are allowed. Erasing the block that holds that byte returns it to all ones, which is the only way to lift protection.

Top module: `flash_sec_gate`

## Requirements
- R1: After reset is released, the gate first reads the reset vector at addresses 0xFFFFC, 0xFFFFD, 0xFFFFE and 0xFFFFF in that order. It then reads the protection byte at 0xFFFDB.
- R2: If any vector byte differs from 0xFF, the gate next reads the seven identification bytes at 0xFFFDF, 0xFFFE3, 0xFFFEB, 0xFFFEF, 0xFFFF3, 0xFFFF7 and 0xFFFFB, in that order. If all four vector bytes are 0xFF, it makes no identification reads and finishes after the protection byte.
- R3: `fl_req_o` stays high and `fl_addr_o` stays unchanged until `fl_valid_i` is sampled high on a rising edge. Exactly one byte is taken per such handshake.
- R4: `cmd_accept_o` and `par_access_o` are low from reset until `check_done_o` is high. Once high, `check_done_o` stays high until the next reset, and `fl_req_o` then stays low.
- R5: In serial mode (`mode_par_i`=0) with a vector that is not blank, `cmd_accept_o` goes high one cycle after the check is complete and the latest submission has ended. This happens only if the submission held exactly seven bytes and byte k matched stored byte k for every k.
- R6: A submission of fewer than seven bytes, or of more than seven bytes, before `id_end_i` gives a fail, so `cmd_accept_o` stays low.
- R7: In serial mode with a blank vector, `cmd_accept_o` is high once the check is complete, whether or not any code was submitted.
- R8: A byte that arrives after an end strobe starts a new submission. `cmd_accept_o` drops low on the next cycle and shows the new verdict only after the next end strobe.
- R9: In parallel mode (`mode_par_i`=1), `par_access_o` is high after the check only when protection-byte bits [7:6] equal 11b. Any other value in those bits holds it low, and bits [5:0] have no effect. `cmd_accept_o` is low in parallel mode.
- R10: `par_access_o` is low in serial mode. The two outputs are never high together, and a change of `mode_par_i` reaches the outputs one cycle later.
- R11: An end strobe in the same cycle as the final identification-byte handshake gives the same verdict as an end strobe that comes later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_par_i | input | 1 | 1 = parallel programming mode, 0 = serial programming mode |
| fl_req_o | output | 1 | Flash read request |
| fl_addr_o | output | AW (20) | Flash byte address |
| fl_valid_i | input | 1 | Read data valid, which completes the request |
| fl_data_i | input | 8 | Read data byte |
| id_valid_i | input | 1 | One submitted identification byte is present |
| id_byte_i | input | 8 | Submitted identification byte |
| id_end_i | input | 1 | End of the submitted identification code |
| check_done_o | output | 1 | All security reads are complete |
| cmd_accept_o | output | 1 | Serial-mode commands are accepted |
| par_access_o | output | 1 | Parallel-mode read and rewrite are allowed |

## Verification
Two events can land in the same cycle: the final identification-byte read, which loads the stored code, and the tool's end strobe, which closes the submission. The bench sends the seven code bytes while the reads are still under way. Its flash model then raises the end strobe in the very cycle it delivers the last stored byte. The check is that the latched verdict is a pass, exactly as when the strobe comes late. A related race, a new byte arriving just after a pass, is judged by the accept output dropping on the next cycle.

// File: rtl/flash_sec_pkg.sv
package flash_sec_pkg;

   localparam int unsigned BYTE_W = 8;

   typedef logic [BYTE_W-1:0] byte_t;

   // Phases of the security-read walk, in the order they are taken.
   typedef enum logic [1:0] {
      PH_VEC  = 2'd0,
      PH_PROT = 2'd1,
      PH_ID   = 2'd2,
      PH_DONE = 2'd3
   } fetch_phase_t;

endpackage

// File: rtl/fsg_fetch_seq.sv
module fsg_fetch_seq
   import flash_sec_pkg::*;
#(
   parameter int unsigned AW          = 20,
   parameter int unsigned VEC_BYTES   = 4,
   parameter int unsigned ID_LEN      = 7,
   parameter int unsigned IDX_W       = 3,
   parameter int unsigned VEC_BASE    = 'hFFFFC,
   parameter int unsigned PROT_ADDR   = 'hFFFDB,
   parameter int unsigned ID_BASE     = 'hFFFDF,
   parameter int unsigned ID_STRIDE   = 4,
   parameter int unsigned ID_SKIP_AT  = 2,
   parameter int unsigned ID_SKIP_GAP = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   output logic             fl_req_o,
   output logic [AW-1:0]    fl_addr_o,
   input  logic             fl_valid_i,
   input  byte_t            fl_data_i,
   output logic             done_o,
   output logic             blank_o,
   output byte_t            prot_o,
   output logic             id_wr_o,
   output logic [IDX_W-1:0] id_wr_idx_o,
   output byte_t            id_wr_data_o
);

   fetch_phase_t     phase_q;
   logic [IDX_W-1:0] idx_q;
   logic             ones_q;
   byte_t            prot_q;
   logic             hs;
   logic             last_vec;
   logic             last_id;
   logic [AW-1:0]    id_gap;

   assign fl_req_o = (phase_q != PH_DONE);
   assign hs       = fl_req_o & fl_valid_i;
   assign last_vec = (idx_q == IDX_W'(VEC_BYTES - 1));
   assign last_id  = (idx_q == IDX_W'(ID_LEN - 1));
   assign id_gap   = (idx_q >= IDX_W'(ID_SKIP_AT)) ? AW'(ID_SKIP_GAP) : '0;

   always_comb begin
      unique case (phase_q)
         PH_VEC:  fl_addr_o = AW'(VEC_BASE) + AW'(idx_q);
         PH_PROT: fl_addr_o = AW'(PROT_ADDR);
         PH_ID:   fl_addr_o = AW'(ID_BASE) + AW'(idx_q) * AW'(ID_STRIDE) + id_gap;
         default: fl_addr_o = '0;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q <= PH_VEC;
         idx_q   <= '0;
         ones_q  <= 1'b1;
         prot_q  <= '1;
      end else if (hs) begin
         unique case (phase_q)
            PH_VEC: begin
               ones_q <= ones_q & (fl_data_i == '1);
               if (last_vec) begin
                  phase_q <= PH_PROT;
                  idx_q   <= '0;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            PH_PROT: begin
               prot_q  <= fl_data_i;
               phase_q <= ones_q ? PH_DONE : PH_ID;
            end
            PH_ID: begin
               if (last_id) phase_q <= PH_DONE;
               else         idx_q   <= idx_q + 1'b1;
            end
            default: phase_q <= PH_DONE;
         endcase
      end
   end

   assign done_o       = (phase_q == PH_DONE);
   assign blank_o      = ones_q;
   assign prot_o       = prot_q;
   assign id_wr_o      = hs & (phase_q == PH_ID);
   assign id_wr_idx_o  = idx_q;
   assign id_wr_data_o = fl_data_i;

endmodule

// File: rtl/fsg_id_cmp.sv
module fsg_id_cmp
   import flash_sec_pkg::*;
#(
   parameter int unsigned ID_LEN = 7,
   parameter int unsigned IDX_W  = 3,
   parameter int unsigned CW     = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             ref_wr_i,
   input  logic [IDX_W-1:0] ref_idx_i,
   input  byte_t            ref_data_i,
   input  logic             id_valid_i,
   input  byte_t            id_byte_i,
   input  logic             id_end_i,
   output logic             sub_done_o,
   output logic             sub_pass_o
);

   logic [CW-1:0]     cnt_q;
   logic              end_q;
   logic [ID_LEN-1:0] match;

   // Submission counter saturates one past the code length so that
   // an overlong code can never look like a complete one.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         end_q <= 1'b0;
      end else begin
         if (id_valid_i) begin
            if (end_q)                       cnt_q <= CW'(1);
            else if (cnt_q < CW'(ID_LEN))    cnt_q <= cnt_q + 1'b1;
            else                             cnt_q <= CW'(ID_LEN + 1);
         end
         if (id_end_i)        end_q <= 1'b1;
         else if (id_valid_i) end_q <= 1'b0;
      end
   end

   for (genvar i = 0; i < ID_LEN; i++) begin : g_slot
      byte_t ref_q;
      byte_t rx_q;
      logic  rx_we;

      assign rx_we = id_valid_i &
                     (end_q ? (i == 0) : (cnt_q == CW'(i)));

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            ref_q <= '1;
            rx_q  <= '0;
         end else begin
            if (ref_wr_i && (ref_idx_i == IDX_W'(i))) ref_q <= ref_data_i;
            if (rx_we)                                rx_q  <= id_byte_i;
         end
      end

      assign match[i] = (rx_q == ref_q);
   end

   assign sub_done_o = end_q;
   assign sub_pass_o = end_q & (cnt_q == CW'(ID_LEN)) & (&match);

endmodule

// File: rtl/fsg_prot_decode.sv
module fsg_prot_decode
   import flash_sec_pkg::*;
#(
   parameter int unsigned FIELD_LSB = 6,
   parameter int unsigned FIELD_W   = 2
) (
   input  byte_t prot_i,
   output logic  active_o
);

   if (FIELD_LSB + FIELD_W > BYTE_W) begin : g_bad_field
      $error("protect field does not fit in one byte");
   end

   // Only the erased state (all ones) leaves the array open.
   assign active_o = (prot_i[FIELD_LSB +: FIELD_W] != '1);

endmodule

// File: rtl/flash_sec_gate.sv
module flash_sec_gate
   import flash_sec_pkg::*;
#(
   parameter int unsigned AW          = 20,
   parameter int unsigned VEC_BYTES   = 4,
   parameter int unsigned ID_LEN      = 7,
   parameter int unsigned VEC_BASE    = 'hFFFFC,
   parameter int unsigned PROT_ADDR   = 'hFFFDB,
   parameter int unsigned ID_BASE     = 'hFFFDF,
   parameter int unsigned ID_STRIDE   = 4,
   parameter int unsigned ID_SKIP_AT  = 2,
   parameter int unsigned ID_SKIP_GAP = 4,
   parameter int unsigned PROT_LSB    = 6,
   parameter int unsigned PROT_W      = 2,
   parameter bit          OUT_REG     = 1'b1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          mode_par_i,
   output logic          fl_req_o,
   output logic [AW-1:0] fl_addr_o,
   input  logic          fl_valid_i,
   input  logic [7:0]    fl_data_i,
   input  logic          id_valid_i,
   input  logic [7:0]    id_byte_i,
   input  logic          id_end_i,
   output logic          check_done_o,
   output logic          cmd_accept_o,
   output logic          par_access_o
);

   localparam int unsigned MAX_WALK = (VEC_BYTES > ID_LEN) ? VEC_BYTES : ID_LEN;
   localparam int unsigned IDX_W    = $clog2(MAX_WALK + 1);
   localparam int unsigned CW       = $clog2(ID_LEN + 2);

   if (ID_LEN < 1 || VEC_BYTES < 1) begin : g_bad_len
      $error("code and vector lengths must be at least one byte");
   end
   if (AW < 8 || AW > 32) begin : g_bad_aw
      $error("address width out of range");
   end

   logic             done;
   logic             blank;
   byte_t            prot;
   logic             id_wr;
   logic [IDX_W-1:0] id_wr_idx;
   byte_t            id_wr_data;
   logic             sub_done;
   logic             sub_pass;
   logic             prot_active;
   logic             accept_d;
   logic             access_d;

   fsg_fetch_seq #(
      .AW(AW), .VEC_BYTES(VEC_BYTES), .ID_LEN(ID_LEN), .IDX_W(IDX_W),
      .VEC_BASE(VEC_BASE), .PROT_ADDR(PROT_ADDR), .ID_BASE(ID_BASE),
      .ID_STRIDE(ID_STRIDE), .ID_SKIP_AT(ID_SKIP_AT), .ID_SKIP_GAP(ID_SKIP_GAP)
   ) u_fetch (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .fl_req_o     (fl_req_o),
      .fl_addr_o    (fl_addr_o),
      .fl_valid_i   (fl_valid_i),
      .fl_data_i    (fl_data_i),
      .done_o       (done),
      .blank_o      (blank),
      .prot_o       (prot),
      .id_wr_o      (id_wr),
      .id_wr_idx_o  (id_wr_idx),
      .id_wr_data_o (id_wr_data)
   );

   fsg_id_cmp #(
      .ID_LEN(ID_LEN), .IDX_W(IDX_W), .CW(CW)
   ) u_cmp (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ref_wr_i   (id_wr),
      .ref_idx_i  (id_wr_idx),
      .ref_data_i (id_wr_data),
      .id_valid_i (id_valid_i),
      .id_byte_i  (id_byte_i),
      .id_end_i   (id_end_i),
      .sub_done_o (sub_done),
      .sub_pass_o (sub_pass)
   );

   fsg_prot_decode #(
      .FIELD_LSB(PROT_LSB), .FIELD_W(PROT_W)
   ) u_prot (
      .prot_i   (prot),
      .active_o (prot_active)
   );

   assign accept_d = ~mode_par_i & done & (blank | sub_pass);
   assign access_d =  mode_par_i & done & ~prot_active;
   assign check_done_o = done;

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            cmd_accept_o <= 1'b0;
            par_access_o <= 1'b0;
         end else begin
            cmd_accept_o <= accept_d;
            par_access_o <= access_d;
         end
      end
   end else begin : g_out_comb
      assign cmd_accept_o = accept_d;
      assign par_access_o = access_d;
   end

endmodule

// File: rtl/flash_sec_gate_chk.sv
module flash_sec_gate_chk #(
   parameter int unsigned AW = 20
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic          fl_req_o,
   input logic [AW-1:0] fl_addr_o,
   input logic          fl_valid_i,
   input logic          check_done_o,
   input logic          cmd_accept_o,
   input logic          par_access_o
);

   assert_hold_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !check_done_o |-> (!cmd_accept_o && !par_access_o));

   assert_done_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      check_done_o |=> check_done_o);

   assert_quiet_after_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      check_done_o |-> !fl_req_o);

   assert_addr_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fl_req_o && !fl_valid_i) |=> (fl_req_o && $stable(fl_addr_o)));

   assert_outputs_exclusive_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(cmd_accept_o && par_access_o));

endmodule

bind flash_sec_gate flash_sec_gate_chk #(.AW(AW)) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .fl_req_o     (fl_req_o),
   .fl_addr_o    (fl_addr_o),
   .fl_valid_i   (fl_valid_i),
   .check_done_o (check_done_o),
   .cmd_accept_o (cmd_accept_o),
   .par_access_o (par_access_o)
);

// File: tb/flash_sec_gate_bench.sv
module flash_sec_gate_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_par = 1'b0;
   logic        fl_req;
   logic [19:0] fl_addr;
   logic        fl_valid = 1'b0;
   logic [7:0]  fl_data = 8'h00;
   logic        id_valid = 1'b0;
   logic [7:0]  id_byte = 8'h00;
   logic        id_end_t = 1'b0;
   logic        id_end_m = 1'b0;
   logic        id_end;
   logic        check_done;
   logic        cmd_accept;
   logic        par_access;

   int checks = 0;
   int errors = 0;

   logic [7:0]  vec_b [4];
   logic [7:0]  prot_b;
   logic [7:0]  idm   [7];
   logic [7:0]  txb   [8];
   int          lat = 0;
   int          wcnt = 0;
   bit          end_on_last = 1'b0;
   logic [19:0] log_a [16];
   int          log_n = 0;

   localparam logic [19:0] VEC_A [4] = '{20'hFFFFC, 20'hFFFFD, 20'hFFFFE, 20'hFFFFF};
   localparam logic [19:0] PROT_A    = 20'hFFFDB;
   localparam logic [19:0] ID_A  [7] = '{20'hFFFDF, 20'hFFFE3, 20'hFFFEB, 20'hFFFEF,
                                         20'hFFFF3, 20'hFFFF7, 20'hFFFFB};

   assign id_end = id_end_t | id_end_m;

   always #5 clk = ~clk;

   flash_sec_gate u_flash_sec_gate (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .mode_par_i   (mode_par),
      .fl_req_o     (fl_req),
      .fl_addr_o    (fl_addr),
      .fl_valid_i   (fl_valid),
      .fl_data_i    (fl_data),
      .id_valid_i   (id_valid),
      .id_byte_i    (id_byte),
      .id_end_i     (id_end),
      .check_done_o (check_done),
      .cmd_accept_o (cmd_accept),
      .par_access_o (par_access)
   );

   function automatic logic [7:0] mem_rd(input logic [19:0] a);
      for (int i = 0; i < 4; i++) if (a == VEC_A[i]) return vec_b[i];
      if (a == PROT_A) return prot_b;
      for (int i = 0; i < 7; i++) if (a == ID_A[i]) return idm[i];
      return 8'h00;
   endfunction

   // Flash model: answers each request after lat idle cycles.
   always @(negedge clk) begin
      if (!rst_n) begin
         fl_valid = 1'b0;
         id_end_m = 1'b0;
         wcnt     = 0;
      end else if (fl_valid) begin
         fl_valid = 1'b0;
         id_end_m = 1'b0;
         wcnt     = 0;
      end else if (fl_req) begin
         if (wcnt >= lat) begin
            fl_valid = 1'b1;
            fl_data  = mem_rd(fl_addr);
            if (end_on_last && fl_addr == ID_A[6]) id_end_m = 1'b1;
         end else begin
            wcnt = wcnt + 1;
         end
      end
   end

   always @(posedge clk) begin
      if (!rst_n) log_n <= 0;
      else if (fl_req && fl_valid) begin
         if (log_n < 16) log_a[log_n] <= fl_addr;
         log_n <= log_n + 1;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic set_code(input bit blank, input logic [7:0] prot);
      if (blank) vec_b = '{8'hFF, 8'hFF, 8'hFF, 8'hFF};
      else       vec_b = '{8'h00, 8'h04, 8'hFF, 8'hFF};
      prot_b = prot;
      idm = '{8'h3A, 8'h91, 8'h5C, 8'h07, 8'hE2, 8'h48, 8'hB6};
      for (int i = 0; i < 7; i++) txb[i] = idm[i];
      txb[7] = 8'h11;
   endtask

   task automatic do_reset(input bit par);
      @(negedge clk);
      rst_n = 1'b0;
      mode_par = par;
      id_valid = 1'b0;
      id_end_t = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wait_done;
      for (int i = 0; i < 400 && !check_done; i++) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic send_id(input int from, input int to, input bit do_end);
      for (int i = from; i < to; i++) begin
         @(negedge clk);
         id_valid = 1'b1;
         id_byte  = txb[i];
      end
      @(negedge clk);
      id_valid = 1'b0;
      if (do_end) begin
         id_end_t = 1'b1;
         @(negedge clk);
         id_end_t = 1'b0;
      end
      repeat (2) @(negedge clk);
   endtask

   task automatic t_reset_state;
      set_code(1'b1, 8'hFF);
      lat = 3;
      do_reset(1'b1);
      @(negedge clk);
      chk("R4 done low after reset", {31'd0, check_done}, 32'd0);
      chk("R4 par_access low before done", {31'd0, par_access}, 32'd0);
      chk("R4 accept low before done", {31'd0, cmd_accept}, 32'd0);
      chk("R1 request raised after reset", {31'd0, fl_req}, 32'd1);
   endtask

   task automatic t_addr_order;
      set_code(1'b0, 8'hFF);
      lat = 2;
      do_reset(1'b0);
      wait_done();
      chk("R3 handshake count nonblank", log_n, 12);
      for (int i = 0; i < 4; i++) chk("R1 vector address order", log_a[i], VEC_A[i]);
      chk("R1 protection address", log_a[4], PROT_A);
      for (int i = 0; i < 7; i++) chk("R2 code address order", log_a[5 + i], ID_A[i]);
      chk("R4 no request after done", {31'd0, fl_req}, 32'd0);
      chk("R5 no accept without submission", {31'd0, cmd_accept}, 32'd0);
   endtask

   task automatic t_match;
      set_code(1'b0, 8'hFF);
      lat = 0;
      do_reset(1'b0);
      wait_done();
      send_id(0, 7, 1'b1);
      chk("R5 matching code accepted", {31'd0, cmd_accept}, 32'd1);
      chk("R10 par_access low in serial", {31'd0, par_access}, 32'd0);
      send_id(0, 1, 1'b0);
      chk("R8 new byte withdraws accept", {31'd0, cmd_accept}, 32'd0);
      send_id(1, 7, 1'b1);
      chk("R8 new submission verdict", {31'd0, cmd_accept}, 32'd1);
      @(negedge clk);
      mode_par = 1'b1;
      @(negedge clk);
      chk("R10 mode switch to parallel, accept", {31'd0, cmd_accept}, 32'd0);
      chk("R10 mode switch to parallel, access", {31'd0, par_access}, 32'd1);
      mode_par = 1'b0;
      @(negedge clk);
      chk("R10 mode switch back, accept", {31'd0, cmd_accept}, 32'd1);
   endtask

   task automatic t_mismatch;
      set_code(1'b0, 8'hFF);
      do_reset(1'b0);
      wait_done();
      txb[5] = 8'h49;
      send_id(0, 7, 1'b1);
      chk("R5 mismatched sixth byte rejected", {31'd0, cmd_accept}, 32'd0);
      txb[5] = idm[5];
      send_id(0, 6, 1'b1);
      chk("R6 short code rejected", {31'd0, cmd_accept}, 32'd0);
      send_id(0, 8, 1'b1);
      chk("R6 long code rejected", {31'd0, cmd_accept}, 32'd0);
      send_id(0, 7, 1'b1);
      chk("R5 exact code after failures", {31'd0, cmd_accept}, 32'd1);
   endtask

   task automatic t_blank;
      set_code(1'b1, 8'hFF);
      lat = 1;
      do_reset(1'b0);
      wait_done();
      chk("R2 blank vector skips code reads", log_n, 5);
      chk("R7 blank vector accepts", {31'd0, cmd_accept}, 32'd1);
      txb[0] = 8'h00;
      send_id(0, 3, 1'b1);
      chk("R7 bad submission still accepted", {31'd0, cmd_accept}, 32'd1);
   endtask

   task automatic t_prot(input logic [7:0] p, input logic exp, input string req);
      set_code(1'b0, p);
      lat = 0;
      do_reset(1'b1);
      wait_done();
      chk(req, {31'd0, par_access}, {31'd0, exp});
      chk("R9 accept low in parallel", {31'd0, cmd_accept}, 32'd0);
   endtask

   task automatic t_par_with_code;
      set_code(1'b0, 8'hFF);
      do_reset(1'b1);
      wait_done();
      send_id(0, 7, 1'b1);
      chk("R9 correct code ignored in parallel", {31'd0, cmd_accept}, 32'd0);
      chk("R9 open array in parallel", {31'd0, par_access}, 32'd1);
   endtask

   task automatic t_same_cycle;
      set_code(1'b0, 8'hFF);
      lat = 3;
      end_on_last = 1'b1;
      do_reset(1'b0);
      send_id(0, 7, 1'b0);
      chk("R11 still reading while code sent", {31'd0, check_done}, 32'd0);
      wait_done();
      end_on_last = 1'b0;
      chk("R11 end with final read accepted", {31'd0, cmd_accept}, 32'd1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      t_reset_state();
      t_addr_order();
      t_match();
      t_mismatch();
      t_blank();
      t_prot(8'hFF, 1'b1, "R9 erased byte opens");
      t_prot(8'h3F, 1'b0, "R9 field 00b blocks");
      t_prot(8'h7F, 1'b0, "R9 field 01b blocks");
      t_prot(8'hBF, 1'b0, "R9 field 10b blocks");
      t_prot(8'hC0, 1'b1, "R9 low bits ignored");
      t_par_with_code();
      t_same_cycle();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule